// File: doc/BRIEF.md
# Weighted Threshold Decision Network

This block decides whether a weighted sum of boolean inputs reaches a fixed threshold. All weights are positive integers and are fixed when the design is elaborated. Each input can be flagged as inverted; an inverted input contributes its weight when the pin is low. The block has no adder and no comparator. It is a tree of 2:1 multiplexers that follows a reduced ordered decision diagram.

Each multiplexer node is keyed by two values: the number of inputs still to be examined and the weight gathered so far. The top node examines the heaviest input. Every level below it examines the next lighter input, down to the lightest. A branch becomes the constant 1 once the gathered weight meets the threshold. It becomes the constant 0 once even all the remaining weight could not reach the threshold. Only keys that can be reached from the top are built, and every key is built once, so branches that arrive at the same key share a single multiplexer.

A thin registered shell samples the input vector on one clock edge and registers the network's verdict on the next.

Top module: `thrdd_top`

## Requirements
- R1: While the synchronous active-high `rst` is asserted, `sat_out` reads 0, and both pipeline registers hold 0.
- R2: `sat_out` is 1 exactly when the effective weight is at least `THRESH`. Input i contributes `WEIGHTS[i*WW +: WW]` when its effective value `lits_in[i] ^ INVERT[i]` is 1. Weights must be non-decreasing with index, so index N-1 is the heaviest and is examined first.
- R3: For an input whose `INVERT` bit is 1, raising the pin removes that input's weight from the effective sum, and lowering the pin adds it.
- R4: A vector presented before clock edge k is reflected on `sat_out` after edge k+1. After edge k alone, `sat_out` still shows the previous vector's verdict.
- R5: Changing one effective literal from 0 to 1 never clears the verdict. Inside the network, the branch that adds the top input's weight is 1 whenever the branch that skips it is 1.
- R6: When the heaviest weight alone reaches `THRESH`, an effective 1 on input N-1 forces `sat_out` to 1.
- R7: If every effective literal is 0, the verdict is 0 (for `THRESH` > 0). If every effective literal is 1, the verdict is 1 exactly when the total weight is at least `THRESH`.
- R8: With all weights equal to 1 and no inversion, the verdict is 1 exactly when the population count of the inputs is at least `THRESH`.
- R9: Outside reset, `sat_out` changes only if the sampled input vector changed on the edge before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lits_in | input | N | Input literal pins, index N-1 heaviest |
| sat_out | output | 1 | Registered verdict: effective weighted sum is at least the threshold |

## Verification
The bench sweeps every input vector of an 8-input weighted configuration that has two inverted inputs, and every vector of a 6-input unit-weight configuration. Each result is compared against a sum of weights computed in the bench.

Several corner cases get targeted checks:
- A vector whose effective sum equals the threshold exactly must give 1. A design that compares with strict greater-than would give 0 here.
- An inverted input whose branches are not swapped would count its weight on the wrong pin level.
- A constant-0 cut that ignores part of the remaining weight would clear verdicts that should be 1. The monotonicity comparison over all single-literal raises catches such a network.
- Sampling the verdict one cycle after the vector is applied detects a shell with the wrong latency.

// File: rtl/thrdd_pkg.sv
package thrdd_pkg;

    // Classification of a (remaining, gathered) key in the decision network
    typedef enum logic [1:0] {
        KIND_ZERO = 2'd0,   // threshold unreachable: constant 0
        KIND_ONE  = 2'd1,   // threshold met: constant 1
        KIND_NODE = 2'd2    // undecided: a multiplexer is needed
    } node_kind_e;

endpackage

// File: rtl/thrdd_node.sv
module thrdd_node (
    input  logic sel,
    input  logic on_one,
    input  logic on_zero,
    output logic y
);

    // One decision node: the literal pin chooses between its two subtrees
    always_comb begin
        y = sel ? on_one : on_zero;
    end

endmodule

// File: rtl/thrdd_net.sv
module thrdd_net
    import thrdd_pkg::*;
#(
    parameter int          N       = 8,
    parameter int          WW      = 4,
    parameter logic [N*WW-1:0] WEIGHTS = 32'h9754_3221,
    parameter logic [N-1:0]    INVERT  = 8'b0001_0010,
    parameter int          THRESH  = 9
) (
    input  logic [N-1:0] lits,
    output logic         sat,
    output logic         add_br,   // top subtree that gathers the top weight
    output logic         skip_br   // top subtree that skips the top weight
);

    localparam int KEYS = (N + 1) * THRESH;

    function automatic int wt(input int i);
        return int'(WEIGHTS[i*WW +: WW]);
    endfunction

    // Weight still available when r inputs (indices 0..r-1) remain
    function automatic int rest(input int r);
        int t;
        t = 0;
        for (int i = 0; i < r; i++) t += wt(i);
        return t;
    endfunction

    function automatic node_kind_e kind_of(input int r, input int s);
        if (s >= THRESH)           return KIND_ONE;
        if (s + rest(r) < THRESH)  return KIND_ZERO;
        return KIND_NODE;
    endfunction

    // Keys reachable from the top; bit index r*THRESH+s
    function automatic logic [KEYS-1:0] reach_map();
        logic [KEYS-1:0] m;
        int g1, g0;
        m = '0;
        if (kind_of(N, 0) == KIND_NODE) m[N*THRESH] = 1'b1;
        for (int r = N; r >= 2; r--) begin
            for (int s = 0; s < THRESH; s++) begin
                if (m[r*THRESH + s]) begin
                    g1 = INVERT[r-1] ? s : s + wt(r-1);
                    g0 = INVERT[r-1] ? s + wt(r-1) : s;
                    if (kind_of(r-1, g1) == KIND_NODE) m[(r-1)*THRESH + g1] = 1'b1;
                    if (kind_of(r-1, g0) == KIND_NODE) m[(r-1)*THRESH + g0] = 1'b1;
                end
            end
        end
        return m;
    endfunction

    localparam logic [KEYS-1:0] REACH = reach_map();
    localparam node_kind_e      TOP_KIND = kind_of(N, 0);

    for (genvar r = 1; r <= N; r++) begin : g_lvl
        for (genvar s = 0; s < THRESH; s++) begin : g_nd
            if (REACH[r*THRESH + s]) begin : g_live
                localparam int         W    = wt(r-1);
                localparam int         SUM1 = INVERT[r-1] ? s : s + W;
                localparam int         SUM0 = INVERT[r-1] ? s + W : s;
                localparam node_kind_e K1   = kind_of(r-1, SUM1);
                localparam node_kind_e K0   = kind_of(r-1, SUM0);
                logic one_v;
                logic zero_v;
                logic val;

                if (K1 == KIND_ONE) begin : g_one_hi
                    assign one_v = 1'b1;
                end else if (K1 == KIND_ZERO) begin : g_one_lo
                    assign one_v = 1'b0;
                end else begin : g_one_sub
                    assign one_v = g_lvl[r-1].g_nd[SUM1].g_live.val;
                end

                if (K0 == KIND_ONE) begin : g_zero_hi
                    assign zero_v = 1'b1;
                end else if (K0 == KIND_ZERO) begin : g_zero_lo
                    assign zero_v = 1'b0;
                end else begin : g_zero_sub
                    assign zero_v = g_lvl[r-1].g_nd[SUM0].g_live.val;
                end

                thrdd_node u_mux (
                    .sel     (lits[r-1]),
                    .on_one  (one_v),
                    .on_zero (zero_v),
                    .y       (val)
                );
            end
        end
    end

    if (TOP_KIND == KIND_NODE) begin : g_top_node
        assign sat = g_lvl[N].g_nd[0].g_live.val;
        if (INVERT[N-1]) begin : g_top_inv
            assign add_br  = g_lvl[N].g_nd[0].g_live.zero_v;
            assign skip_br = g_lvl[N].g_nd[0].g_live.one_v;
        end else begin : g_top_pos
            assign add_br  = g_lvl[N].g_nd[0].g_live.one_v;
            assign skip_br = g_lvl[N].g_nd[0].g_live.zero_v;
        end
    end else begin : g_top_const
        assign sat     = (TOP_KIND == KIND_ONE);
        assign add_br  = (TOP_KIND == KIND_ONE);
        assign skip_br = (TOP_KIND == KIND_ONE);
    end

endmodule

// File: rtl/thrdd_top.sv
module thrdd_top #(
    parameter int          N       = 8,
    parameter int          WW      = 4,
    parameter logic [N*WW-1:0] WEIGHTS = 32'h9754_3221,
    parameter logic [N-1:0]    INVERT  = 8'b0001_0010,
    parameter int          THRESH  = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lits_in,
    output logic         sat_out
);

    function automatic int total_wt();
        int t;
        t = 0;
        for (int i = 0; i < N; i++) t += int'(WEIGHTS[i*WW +: WW]);
        return t;
    endfunction

    localparam int           TOTAL  = total_wt();
    localparam int           HEAVY  = int'(WEIGHTS[(N-1)*WW +: WW]);
    localparam logic [N-1:0] ALL_ON = ~INVERT;

    logic [N-1:0] in_q;
    logic         sat_q;
    logic         net_sat;
    logic         add_br;
    logic         skip_br;

    thrdd_net #(
        .N       (N),
        .WW      (WW),
        .WEIGHTS (WEIGHTS),
        .INVERT  (INVERT),
        .THRESH  (THRESH)
    ) u_net (
        .lits    (in_q),
        .sat     (net_sat),
        .add_br  (add_br),
        .skip_br (skip_br)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            sat_q <= 1'b0;
        end else begin
            in_q  <= lits_in;
            sat_q <= net_sat;
        end
    end

    assign sat_out = sat_q;

    // R5: gathering the top weight can only help
    assert_monotone_top_R5: assert property (@(posedge clk) disable iff (rst)
        skip_br |-> add_br);

    // R7: every effective literal 0 gives no verdict
    if (THRESH > 0) begin : g_chk_off
        assert_all_off_R7: assert property (@(posedge clk) disable iff (rst)
            (in_q == INVERT) |=> !sat_q);
    end

    // R7: every effective literal 1 meets a reachable threshold
    if (TOTAL >= THRESH) begin : g_chk_on
        assert_all_on_R7: assert property (@(posedge clk) disable iff (rst)
            (in_q == ALL_ON) |=> sat_q);
    end

    // R6: the heaviest input alone suffices when its weight reaches the threshold
    if (HEAVY >= THRESH) begin : g_chk_heavy
        assert_heavy_alone_R6: assert property (@(posedge clk) disable iff (rst)
            (in_q[N-1] != INVERT[N-1]) |=> sat_q);
    end

    // R9: the verdict moves only after a change of the sampled vector
    assert_stable_out_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (sat_q != $past(sat_q))) |-> ($past(in_q) != $past(in_q, 2)));

endmodule

// File: tb/thrdd_top_test.sv
`timescale 1ns/1ps
module thrdd_top_test;

    localparam int        N_A   = 8;
    localparam int        WW_A  = 4;
    localparam logic [31:0] W_A = 32'h9754_3221;   // idx0..7: 1,2,2,3,4,5,7,9
    localparam logic [7:0]  I_A = 8'b0001_0010;    // idx1 and idx4 inverted
    localparam int        T_A   = 9;

    localparam int        N_B   = 6;
    localparam int        WW_B  = 2;
    localparam logic [11:0] W_B = 12'h555;         // all weights 1
    localparam int        T_B   = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N_A-1:0] lits_a = '0;
    logic [N_B-1:0] lits_b = '0;
    logic           sat_a;
    logic           sat_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit res_a [256];

    always #2.5 clk = ~clk;

    thrdd_top #(.N(N_A), .WW(WW_A), .WEIGHTS(W_A), .INVERT(I_A), .THRESH(T_A)) uut (
        .clk(clk), .rst(rst), .lits_in(lits_a), .sat_out(sat_a));

    thrdd_top #(.N(N_B), .WW(WW_B), .WEIGHTS(W_B), .INVERT(6'b0), .THRESH(T_B)) uut_card (
        .clk(clk), .rst(rst), .lits_in(lits_b), .sat_out(sat_b));

    function automatic bit exp_a(input logic [7:0] v);
        int s;
        s = 0;
        for (int i = 0; i < N_A; i++)
            if (v[i] ^ I_A[i]) s += int'((W_A >> (4*i)) & 32'hF);
        return s >= T_A;
    endfunction

    function automatic bit exp_b(input logic [5:0] v);
        return $countones(v) >= T_B;
    endfunction

    task automatic chk(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit prev;
        logic [7:0] u;
        repeat (3) @(negedge clk);
        chk(sat_a, 1'b0, "R1 reset verdict uut");
        chk(sat_b, 1'b0, "R1 reset verdict uut_card");
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        prev = exp_a(8'h00);

        // Exhaustive sweep, weighted configuration
        for (int v = 0; v < 256; v++) begin
            lits_a = v[7:0];
            @(negedge clk);
            chk(sat_a, prev, $sformatf("R4 one-edge latency v=%0h", v));
            @(negedge clk);
            chk(sat_a, exp_a(v[7:0]), $sformatf("R2 verdict v=%0h", v));
            res_a[v] = sat_a;
            prev = exp_a(v[7:0]);
        end

        // R3: inverted idx1 (weight 2) with idx6 (weight 7): sum exactly 9
        chk(res_a[8'h50], 1'b1, "R3 inverted pin low adds weight");
        chk(res_a[8'h52], 1'b0, "R3 inverted pin high removes weight");

        // R5: raising any effective literal never clears the verdict
        for (int v = 0; v < 256; v++) begin
            for (int i = 0; i < N_A; i++) begin
                if (v[i] == I_A[i]) begin
                    u = v[7:0] ^ (8'h1 << i);
                    if (res_a[v]) chk(res_a[u], 1'b1, $sformatf("R5 monotone v=%0h bit %0d", v, i));
                end
            end
        end

        // R6: heaviest input (weight 9) alone
        for (int v = 0; v < 256; v++)
            if (v[7] ^ I_A[7]) chk(res_a[v], 1'b1, $sformatf("R6 heavy literal v=%0h", v));

        // R7: all effective off / all effective on
        chk(res_a[I_A], 1'b0, "R7 all effective literals off");
        chk(res_a[~I_A], 1'b1, "R7 all effective literals on");

        // R8: cardinality configuration, exhaustive
        for (int v = 0; v < 64; v++) begin
            lits_b = v[5:0];
            @(negedge clk);
            @(negedge clk);
            chk(sat_b, exp_b(v[5:0]), $sformatf("R8 cardinality v=%0h", v));
        end

        // R9: held input keeps the verdict
        lits_a = 8'h50;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(sat_a, 1'b1, "R9 held input stable verdict");
        end

        finish_run();
    end

endmodule